// File: doc/BRIEF.md
# Oscillation Settling Wait Timer

This block holds back the processor clock while the main oscillator settles. After a system reset, or after a wake-up from the STOP low-power state, it keeps its clock-stable output low and counts main-clock cycles. The count starts only once the oscillator reports that it is running, and the clock is released when the count is done. The length of the wait is a power of two, chosen by a three-bit code that software writes into an 8-bit select register.

Five codes are legal. Each one picks a fixed exponent (12, 14, 15, 16 or 17), and reset loads the code for the longest wait. The three other codes are not allowed, and a write of one of them is dropped. The code in use is captured when counting begins, so a write made while a wait is in progress only takes effect on the next wait. A STOP request pulse clears the count and pulls the output low in the same cycle. A wake pulse then starts a new wait. A `SCALE_SHIFT` parameter subtracts a constant from every exponent so that a simulation can be short.

Top module: `osc_settle_timer`

## Requirements
- R1: Code 0 waits 2^(12-S) cycles, code 1 waits 2^(14-S), code 2 waits 2^(15-S), code 3 waits 2^(16-S) and code 4 waits 2^(17-S), where S is `SCALE_SHIFT`. If `osc_running` is first sampled high at rising edge k of a wait of W cycles, then `clk_stable` is low after edge k+W-1 and high after edge k+W.
- R2: A write whose bits [2:0] hold 5, 6 or 7 is ignored, and the register keeps its previous value.
- R3: Reset loads the select register with 0x04 and holds `clk_stable` low. The wait that follows a reset uses code 4, the longest wait.
- R4: A legal write stores `sel_wr_data[2:0]`. `sel_rd_data[7:3]` always reads zero.
- R5: A wait is run both after a reset and after a `wake_req` pulse while the block is in STOP.
- R6: While `osc_running` is low before the count starts, `clk_stable` stays low and no cycles are counted.
- R7: Once high, `clk_stable` stays high until `stop_req` or `rst`. A `wake_req` pulse in that state has no effect.
- R8: `clk_stable` is low in any cycle in which `stop_req` is high. A STOP request clears the count, so the next wait runs its full length.
- R9: The code is captured on the edge at which counting starts. A write made during a wait changes the register but not the length of that wait.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Main clock |
| rst | input | 1 | Synchronous active-high reset, which also acts as a wake source |
| sel_wr_en | input | 1 | Write strobe for the select register |
| sel_wr_data | input | 8 | Write data; bits [2:0] hold the code |
| sel_rd_data | output | 8 | Register read value; bits [7:3] are zero |
| stop_req | input | 1 | One-cycle pulse to enter STOP |
| wake_req | input | 1 | One-cycle pulse that leaves STOP (interrupt wake) |
| osc_running | input | 1 | High while the oscillator is running |
| clk_stable | output | 1 | High once the clock may be released |

## Verification
The bench builds the block with `SCALE_SHIFT` set to 8. This shrinks the five waits to 16, 64, 128, 256 and 512 cycles. With waits that short, every legal code can have its exact release edge checked. The same setting also makes it practical to check the long reset wait, a count interrupted by STOP, an oscillator that starts late, and a write made in the middle of a wait.

// File: rtl/osw_pkg.sv
package osw_pkg;

    typedef enum logic [1:0] {
        ST_WAIT_OSC,
        ST_COUNT,
        ST_STABLE,
        ST_STOPPED
    } osw_state_e;

    typedef struct packed {
        logic start;
        logic advance;
        logic clear;
    } cnt_cmd_t;

    localparam int unsigned CODE_W     = 3;
    localparam int unsigned REG_W      = 8;
    localparam logic [2:0]  RESET_CODE = 3'd4;
    localparam logic [2:0]  LAST_LEGAL = 3'd4;
    localparam int unsigned MAX_EXP    = 17;

    function automatic logic code_legal(input logic [2:0] c);
        return c <= LAST_LEGAL;
    endfunction

    function automatic int unsigned code_exp(input logic [2:0] c);
        case (c)
            3'd0:    return 12;
            3'd1:    return 14;
            3'd2:    return 15;
            3'd3:    return 16;
            default: return 17;
        endcase
    endfunction

endpackage

// File: rtl/osw_sel_reg.sv
module osw_sel_reg
    import osw_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                wr_en,
    input  logic [REG_W-1:0]    wr_data,
    output logic [CODE_W-1:0]   code,
    output logic [REG_W-1:0]    rd_data
);

    logic [CODE_W-1:0] code_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            code_q <= RESET_CODE;
        end else if (wr_en && code_legal(wr_data[CODE_W-1:0])) begin
            code_q <= wr_data[CODE_W-1:0];
        end
    end

    assign code    = code_q;
    assign rd_data = {{(REG_W-CODE_W){1'b0}}, code_q};

endmodule

// File: rtl/osw_wait_cnt.sv
module osw_wait_cnt
    import osw_pkg::*;
#(
    parameter int unsigned SCALE_SHIFT = 0,
    parameter int unsigned CNT_W       = MAX_EXP - SCALE_SHIFT
) (
    input  logic              clk,
    input  logic              rst,
    input  cnt_cmd_t          cmd,
    input  logic [CODE_W-1:0] code_in,
    output logic              done
);

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] limit_q;
    logic [CNT_W-1:0] limit_d;

    always_comb begin
        limit_d = CNT_W'((64'd1 << (code_exp(code_in) - SCALE_SHIFT)) - 64'd1);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q   <= '0;
            limit_q <= '0;
        end else if (cmd.clear) begin
            cnt_q   <= '0;
        end else if (cmd.start) begin
            cnt_q   <= '0;
            limit_q <= limit_d;
        end else if (cmd.advance) begin
            cnt_q   <= cnt_q + 1'b1;
        end
    end

    assign done = (cnt_q == limit_q);

endmodule

// File: rtl/osw_ctrl.sv
module osw_ctrl
    import osw_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     stop_req,
    input  logic     wake_req,
    input  logic     osc_running,
    input  logic     cnt_done,
    output cnt_cmd_t cmd,
    output logic     clk_stable
);

    osw_state_e state_q;
    osw_state_e state_d;

    always_comb begin
        state_d = state_q;
        cmd     = '0;
        case (state_q)
            ST_WAIT_OSC: begin
                if (osc_running) begin
                    cmd.start = 1'b1;
                    state_d   = ST_COUNT;
                end
            end
            ST_COUNT: begin
                if (osc_running) begin
                    if (cnt_done) begin
                        state_d = ST_STABLE;
                    end else begin
                        cmd.advance = 1'b1;
                    end
                end
            end
            ST_STOPPED: begin
                if (wake_req) begin
                    state_d = ST_WAIT_OSC;
                end
            end
            default: ;
        endcase
        if (stop_req && state_q != ST_STOPPED) begin
            cmd       = '0;
            cmd.clear = 1'b1;
            state_d   = ST_STOPPED;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_WAIT_OSC;
        end else begin
            state_q <= state_d;
        end
    end

    assign clk_stable = (state_q == ST_STABLE) && !stop_req;

endmodule

// File: rtl/osc_settle_timer.sv
module osc_settle_timer
    import osw_pkg::*;
#(
    parameter int unsigned SCALE_SHIFT = 0
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       sel_wr_en,
    input  logic [7:0] sel_wr_data,
    output logic [7:0] sel_rd_data,
    input  logic       stop_req,
    input  logic       wake_req,
    input  logic       osc_running,
    output logic       clk_stable
);

    localparam int unsigned CNT_W = MAX_EXP - SCALE_SHIFT;

    logic [CODE_W-1:0] code;
    cnt_cmd_t          cmd;
    logic              cnt_done;

    osw_sel_reg u_reg (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (sel_wr_en),
        .wr_data (sel_wr_data),
        .code    (code),
        .rd_data (sel_rd_data)
    );

    osw_wait_cnt #(
        .SCALE_SHIFT (SCALE_SHIFT),
        .CNT_W       (CNT_W)
    ) u_cnt (
        .clk     (clk),
        .rst     (rst),
        .cmd     (cmd),
        .code_in (code),
        .done    (cnt_done)
    );

    osw_ctrl u_ctrl (
        .clk         (clk),
        .rst         (rst),
        .stop_req    (stop_req),
        .wake_req    (wake_req),
        .osc_running (osc_running),
        .cnt_done    (cnt_done),
        .cmd         (cmd),
        .clk_stable  (clk_stable)
    );

endmodule

// File: rtl/osw_checker.sv
module osw_checker
    import osw_pkg::*;
(
    input logic       clk,
    input logic       rst,
    input logic       sel_wr_en,
    input logic [7:0] sel_wr_data,
    input logic [7:0] sel_rd_data,
    input logic       stop_req,
    input logic       wake_req,
    input logic       osc_running,
    input logic       clk_stable
);

    AST_RESET_VALUE: assert property (@(posedge clk)
        rst |=> (sel_rd_data == 8'h04) && !clk_stable); // R3

    AST_UPPER_BITS_ZERO: assert property (@(posedge clk) disable iff (rst)
        sel_rd_data[7:3] == 5'd0); // R4

    AST_BAD_CODE_DROPPED: assert property (@(posedge clk) disable iff (rst)
        (sel_wr_en && !code_legal(sel_wr_data[2:0])) |=> $stable(sel_rd_data)); // R2

    AST_STOP_DROPS_OUTPUT: assert property (@(posedge clk) disable iff (rst)
        stop_req |-> !clk_stable); // R8

    AST_STABLE_HOLDS: assert property (@(posedge clk) disable iff (rst)
        clk_stable |=> (clk_stable || stop_req)); // R7

    AST_RELEASE_NEEDS_OSC: assert property (@(posedge clk) disable iff (rst)
        $rose(clk_stable) |-> $past(osc_running)); // R6

endmodule

bind osc_settle_timer osw_checker u_chk (.*);

// File: tb/tb_osc_settle_timer.sv
`timescale 1ns/1ps
module tb_osc_settle_timer;

    localparam int unsigned SHIFT = 8;

    logic       clk = 1'b0;
    logic       rst;
    logic       sel_wr_en;
    logic [7:0] sel_wr_data;
    logic [7:0] sel_rd_data;
    logic       stop_req;
    logic       wake_req;
    logic       osc_running;
    logic       clk_stable;

    int n_checks = 0;
    int n_fail   = 0;

    always #2.5 clk = ~clk;

    osc_settle_timer #(.SCALE_SHIFT(SHIFT)) dut (
        .clk         (clk),
        .rst         (rst),
        .sel_wr_en   (sel_wr_en),
        .sel_wr_data (sel_wr_data),
        .sel_rd_data (sel_rd_data),
        .stop_req    (stop_req),
        .wake_req    (wake_req),
        .osc_running (osc_running),
        .clk_stable  (clk_stable)
    );

    // {write data, expected read value, expected wait length}
    localparam logic [31:0] VEC [9] = '{
        {8'h00, 8'h00, 16'd16},
        {8'h01, 8'h01, 16'd64},
        {8'hA2, 8'h02, 16'd128},
        {8'h03, 8'h03, 16'd256},
        {8'hF4, 8'h04, 16'd512},
        {8'h01, 8'h01, 16'd64},
        {8'h05, 8'h01, 16'd64},
        {8'h02, 8'h02, 16'd128},
        {8'h07, 8'h02, 16'd128}
    };

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] d);
        @(negedge clk);
        sel_wr_en   = 1'b1;
        sel_wr_data = d;
        @(negedge clk);
        sel_wr_en   = 1'b0;
    endtask

    task automatic stop_wake(input string req);
        @(negedge clk);
        stop_req    = 1'b1;
        osc_running = 1'b0;
        #1;
        chk(req, "stable during stop request", clk_stable, 0);
        @(negedge clk);
        stop_req = 1'b0;
        wake_req = 1'b1;
        @(negedge clk);
        wake_req = 1'b0;
    endtask

    task automatic run_wait(input int n, input string req);
        repeat (3) @(negedge clk);
        chk(req, "stable before oscillator", clk_stable, 0);
        @(negedge clk);
        osc_running = 1'b1;
        for (int i = 1; i <= n + 1; i++) begin
            @(posedge clk);
            #1;
            if (i == n)     chk(req, "stable one edge early", clk_stable, 0);
            if (i == n + 1) chk(req, "stable at release edge", clk_stable, 1);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end

    initial begin
        rst = 1'b1; sel_wr_en = 1'b0; sel_wr_data = 8'h00;
        stop_req = 1'b0; wake_req = 1'b0; osc_running = 1'b0;
        repeat (4) @(negedge clk);
        chk("R3", "reset register value", sel_rd_data, 8'h04);
        chk("R3", "reset stable low", clk_stable, 0);
        rst = 1'b0;
        run_wait(512, "R3");

        // R7: a wake pulse while stable is ignored
        @(negedge clk); wake_req = 1'b1;
        @(negedge clk); wake_req = 1'b0;
        repeat (10) @(negedge clk);
        chk("R7", "stable after wake pulse", clk_stable, 1);

        // R1 R2 R4 R5: table of codes
        for (int v = 0; v < 9; v++) begin
            wr(VEC[v][31:24]);
            chk((VEC[v][31:24] & 8'h07) > 4 ? "R2" : "R4", "register read",
                sel_rd_data, VEC[v][23:16]);
            stop_wake("R5");
            run_wait(int'(VEC[v][15:0]), "R1");
        end

        // R8: STOP in the middle of a count restarts from zero
        wr(8'h00);
        stop_wake("R8");
        @(negedge clk); osc_running = 1'b1;
        repeat (10) @(negedge clk);
        chk("R8", "stable mid count", clk_stable, 0);
        stop_wake("R8");
        run_wait(16, "R8");

        // R6: late oscillator start
        stop_wake("R6");
        repeat (40) @(negedge clk);
        chk("R6", "stable while oscillator off", clk_stable, 0);
        run_wait(16, "R6");

        // R9: a write during the wait does not change its length
        stop_wake("R9");
        @(negedge clk); osc_running = 1'b1;
        for (int i = 1; i <= 17; i++) begin
            @(posedge clk);
            #1;
            if (i == 3) begin sel_wr_en = 1'b1; sel_wr_data = 8'h04; end
            if (i == 4) sel_wr_en = 1'b0;
            if (i == 16) chk("R9", "stable one edge early", clk_stable, 0);
            if (i == 17) chk("R9", "stable at release edge", clk_stable, 1);
        end
        chk("R9", "register after write", sel_rd_data, 8'h04);

        // R3 R5: reset from stable selects the longest wait again
        wr(8'h00);
        @(negedge clk); rst = 1'b1; osc_running = 1'b0;
        @(negedge clk);
        chk("R3", "stable during reset", clk_stable, 0);
        chk("R3", "register during reset", sel_rd_data, 8'h04);
        rst = 1'b0;
        run_wait(512, "R5");

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end

endmodule